// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block turns one fast source clock into four banks of divided clocks carried on nine output lines. Two reference clocks arrive at its edge: a differential pair and a single-ended line. A reference-choice input picks one of them. A mode input then decides what drives the dividers. In bypass mode the chosen reference drives them directly. In normal mode an already synthesized high-rate clock drives them, and that clock enters as an ordinary input.

Each bank has its own pair of ratios and its own select pin. Bank A divides by two or four. Banks B, C and D divide by four or eight. Every output is a registered square wave launched from the divider source clock. A single active-high disable floats all nine lines and holds every divider at its starting count. When the disable is released, all banks start in phase on the same source edge.

Top module: `multibank_clk_div`

## Requirements
- R1: There are four banks with 1, 1, 2 and 5 lines (banks A, B, C, D). All lines of a bank carry the same waveform. `bank_sel[0]` selects for bank A, `[1]` for B, `[2]` for C and `[3]` for D.
- R2: Bank A divides the source clock by 2 when its select is 0 and by 4 when its select is 1.
- R3: Banks B, C and D each divide by 4 when their own select is 0 and by 8 when it is 1. The selects are independent of each other.
- R4: With `pll_en` at 0, `ref_sel` at 0 picks the differential reference (`ref_diff_p` high with `ref_diff_n` low reads as high) and `ref_sel` at 1 picks `ref_se_clk`.
- R5: `pll_en` at 0 drives the dividers from the chosen reference. `pll_en` at 1 drives them from `vco_clk`.
- R6: While `out_dis` is 1, every output line is undriven (high impedance) and the dividers are held at count zero. While it is 0, every line is driven.
- R7: After `out_dis` falls, every bank's output rises on the first rising source edge.
- R8: Each output is high for exactly half of its period. It changes only just after a rising source edge.
- R9: A change on a bank select is taken up only at the start of that bank's next output period. A period that is already running finishes at its old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_se_clk | input | 1 | Single-ended reference clock |
| ref_diff_p | input | 1 | Differential reference clock, true leg |
| ref_diff_n | input | 1 | Differential reference clock, complement leg |
| vco_clk | input | 1 | Synthesized high-rate clock |
| ref_sel | input | 1 | 0: differential reference, 1: single-ended reference |
| pll_en | input | 1 | 0: bypass with reference, 1: dividers run from vco_clk |
| bank_sel | input | 4 | Per-bank ratio select, bit 0 = bank A through bit 3 = bank D |
| out_dis | input | 1 | 1: float all outputs and reset dividers |
| out_a | output | 1 | Bank A line |
| out_b | output | 1 | Bank B line |
| out_c | output | 2 | Bank C lines |
| out_d | output | 5 | Bank D lines |

## Verification
The hardest state to reach is a select that flips in the middle of a period while other banks sit at a different phase of their own ratio. Under that condition the deferred pick-up and the exact high time of every bank are checked at the same moment. The stimulus flips selects at random between source edges, at a rate that lands changes in every phase of every ratio. It also sweeps the source and reference choices under the disable. The bench follows whichever clock its requirements name as the source, so a wrong clock choice appears at once as edge mismatches.

// File: rtl/mbcd_pkg.sv
package mbcd_pkg;

    localparam int NUM_BANKS = 4;
    localparam int MAX_RATIO = 8;
    localparam int CNT_W     = $clog2(MAX_RATIO);

    // lines carried by each bank
    function automatic int bank_lines(int b);
        return (b == 3) ? 5 : (b == 2) ? 2 : 1;
    endfunction

    // ratio used when a bank's select is low
    function automatic int ratio_lo(int b);
        return (b == 0) ? 2 : 4;
    endfunction

    // ratio used when a bank's select is high
    function automatic int ratio_hi(int b);
        return (b == 0) ? 4 : 8;
    endfunction

    typedef enum logic {SRC_REF = 1'b0, SRC_VCO = 1'b1} src_mode_e;

endpackage

// File: rtl/mbcd_src_mux.sv
module mbcd_src_mux
    import mbcd_pkg::*;
(
    input  logic ref_se_clk,
    input  logic ref_diff_p,
    input  logic ref_diff_n,
    input  logic vco_clk,
    input  logic ref_sel,
    input  logic pll_en,
    output logic src_clk
);

    logic diff_clk;
    logic ref_clk;

    always_comb begin
        diff_clk = ref_diff_p & ~ref_diff_n;
        ref_clk  = ref_sel ? ref_se_clk : diff_clk;
        src_clk  = (src_mode_e'(pll_en) == SRC_VCO) ? vco_clk : ref_clk;
    end

endmodule

// File: rtl/mbcd_bank_div.sv
module mbcd_bank_div #(
    parameter int RATIO_LO = 4,
    parameter int RATIO_HI = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    output logic div_o
);

    localparam int CW = $clog2(RATIO_HI);
    localparam int RW = CW + 1;
    localparam logic [CW-1:0] FALL_LO = CW'((RATIO_LO / 2 + 1) % RATIO_LO);
    localparam logic [CW-1:0] FALL_HI = CW'((RATIO_HI / 2 + 1) % RATIO_HI);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hi;
        logic          q;
    } div_state_t;

    div_state_t s_d, s_q;
    logic          pick_hi;
    logic [RW-1:0] ratio;
    logic [RW-1:0] cur_ratio;

    always_comb begin
        pick_hi   = (s_q.cnt == '0) ? sel : s_q.hi;
        ratio     = pick_hi ? RW'(RATIO_HI) : RW'(RATIO_LO);
        cur_ratio = s_q.hi ? RW'(RATIO_HI) : RW'(RATIO_LO);
        s_d.hi    = pick_hi;
        s_d.q     = ({1'b0, s_q.cnt} < (ratio >> 1));
        s_d.cnt   = ({1'b0, s_q.cnt} == ratio - RW'(1)) ? '0 : s_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign div_o = s_q.q;

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.cnt != '0) |-> (s_d.hi == s_q.hi));

    // R7
    rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!s_q.q && s_d.q) |-> (s_q.cnt == '0));

    // R8
    fall_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.q && !s_d.q) |-> (s_d.cnt == (s_q.hi ? FALL_HI : FALL_LO)));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, s_q.cnt} < cur_ratio));

endmodule

// File: rtl/multibank_clk_div.sv
module multibank_clk_div
    import mbcd_pkg::*;
(
    input  logic       ref_se_clk,
    input  logic       ref_diff_p,
    input  logic       ref_diff_n,
    input  logic       vco_clk,
    input  logic       ref_sel,
    input  logic       pll_en,
    input  logic [3:0] bank_sel,
    input  logic       out_dis,
    output logic       out_a,
    output logic       out_b,
    output logic [1:0] out_c,
    output logic [4:0] out_d
);

    logic                 src_clk;
    logic [NUM_BANKS-1:0] bank_clk;

    mbcd_src_mux u_src (
        .ref_se_clk (ref_se_clk),
        .ref_diff_p (ref_diff_p),
        .ref_diff_n (ref_diff_n),
        .vco_clk    (vco_clk),
        .ref_sel    (ref_sel),
        .pll_en     (pll_en),
        .src_clk    (src_clk)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        mbcd_bank_div #(
            .RATIO_LO (ratio_lo(b)),
            .RATIO_HI (ratio_hi(b))
        ) u_div (
            .clk   (src_clk),
            .rst   (out_dis),
            .sel   (bank_sel[b]),
            .div_o (bank_clk[b])
        );
    end

    // R1 R6: fan each bank out to its lines, floated while disabled
    assign out_a = out_dis ? 1'bz : bank_clk[0];
    assign out_b = out_dis ? 1'bz : bank_clk[1];
    assign out_c = out_dis ? {bank_lines(2){1'bz}} : {bank_lines(2){bank_clk[2]}};
    assign out_d = out_dis ? {bank_lines(3){1'bz}} : {bank_lines(3){bank_clk[3]}};

endmodule

// File: tb/multibank_clk_div_tb.sv
`timescale 1ns/1ps
module multibank_clk_div_tb;

    logic vco = 1'b0, se = 1'b0, dp = 1'b0;
    logic ref_sel = 1'b0, pll_en = 1'b1, dis = 1'b1;
    logic [3:0] sel = 4'b0;
    wire        wa, wb;
    wire  [1:0] wc;
    wire  [4:0] wd;

    always #2 vco = ~vco;
    always #5 se  = ~se;
    always #3 dp  = ~dp;

    // source named by R4/R5
    wire src_mon = pll_en ? vco : (ref_sel ? se : dp);

    multibank_clk_div u_dut (
        .ref_se_clk(se), .ref_diff_p(dp), .ref_diff_n(~dp), .vco_clk(vco),
        .ref_sel(ref_sel), .pll_en(pll_en), .bank_sel(sel), .out_dis(dis),
        .out_a(wa), .out_b(wb), .out_c(wc), .out_d(wd)
    );

    int n_chk = 0, n_fail = 0;
    int mcnt[4], mrat[4];
    bit mq[4];
    bit done = 0;

    function automatic int rlo(int b); return (b == 0) ? 2 : 4; endfunction
    function automatic int rhi(int b); return (b == 0) ? 4 : 8; endfunction

    task automatic chk(bit ok, string tag, logic got, logic exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 4; b++) begin mcnt[b] = 0; mrat[b] = rlo(b); mq[b] = 0; end
    endtask

    function automatic logic line0(int b);
        case (b)
            0: return wa;
            1: return wb;
            2: return wc[0];
            default: return wd[0];
        endcase
    endfunction

    // one source edge: advance model, compare all lines
    task automatic step(string tag);
        @(posedge src_mon);
        #1;
        for (int b = 0; b < 4; b++) begin
            int r;
            r = (mcnt[b] == 0) ? (sel[b] ? rhi(b) : rlo(b)) : mrat[b];
            mq[b]   = (mcnt[b] < r / 2);
            mrat[b] = r;
            mcnt[b] = (mcnt[b] == r - 1) ? 0 : mcnt[b] + 1;
            chk(line0(b) === mq[b], tag, line0(b), mq[b]);
        end
        chk(wc[1] === wc[0], "R1 bank C lines", wc[1], wc[0]);
        chk(wd === {5{wd[0]}}, "R1 bank D lines", wd[4], wd[0]);
    endtask

    task automatic check_floated();
        chk(wa !== 1'b1, "R6 out_a", wa, 1'b0);
        chk(wb !== 1'b1, "R6 out_b", wb, 1'b0);
        chk(wc[0] !== 1'b1 && wc[1] !== 1'b1, "R6 out_c", wc[0], 1'b0);
        chk(wd === 5'b0 || wd === 5'bz, "R6 out_d", wd[0], 1'b0);
    endtask

    // disable, reconfigure source, release away from an edge
    task automatic reconf(logic rs, logic pe, string tag);
        dis = 1'b1;
        #1;
        model_reset();
        check_floated();
        ref_sel = rs;
        pll_en  = pe;
        #13;
        check_floated();
        @(posedge src_mon);
        #1;
        dis = 1'b0;
        step(tag);
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h1357);
        model_reset();
        #10;
        check_floated();                       // R6 reset state
        @(posedge vco); #1;
        dis = 1'b0;
        step("R7 first edge vco");
        for (int i = 0; i < 16; i++) step("R2 R3 low ratios");
        sel = 4'b1111;
        for (int i = 0; i < 3; i++) step("R9 mid-period switch");
        for (int i = 0; i < 24; i++) step("R3 high ratios");
        reconf(1'b0, 1'b0, "R4 R7 diff bypass");
        for (int i = 0; i < 20; i++) step("R4 diff ref");
        reconf(1'b1, 1'b0, "R4 R7 se bypass");
        for (int i = 0; i < 20; i++) step("R5 se bypass");
        reconf(1'b1, 1'b1, "R5 R7 back to vco");
        sel = 4'b0101;
        for (int i = 0; i < 20; i++) step("R3 independent selects");
        for (int k = 0; k < 40; k++) begin
            reconf(1'($urandom_range(1)), 1'($urandom_range(1)), "R5 R7 random config");
            for (int i = 0; i < 40; i++) begin
                if ($urandom_range(5) == 0) sel[$urandom_range(3)] ^= 1'b1;
                step("R8 R9 random selects");
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule